// File: doc/BRIEF.md
# Mixed-Mode Self-Test Phase Sequencer

This block runs a two-phase self-test of a combinational (or full-scan) logic cone. After a start pulse it drives a pattern generator forward by one word per cycle. For a programmable number of cycles it passes the raw generator words straight to the inputs of the logic under test. For a second programmable number of cycles it passes words from an external decoder, which transforms the same generator stream into deterministic patterns.

The choice between raw and decoded words is made by one multiplexer per tested input, and all of them follow a single mode signal. A parameter mask marks inputs whose decoded value always equals the raw bit. Those inputs are wired straight through and take no multiplexer. The response of the logic under test is folded into a signature register on every test cycle of both phases. The final signature is held for comparison once the run is complete.

Top module: `bist_phase_seq`

## Requirements
- R1: After synchronous reset, `done`, `mode_det` and `gen_step` are 0 and `signature` equals the `SIG_SEED` parameter.
- R2: A `start` pulse seen while idle or finished latches `rand_len` and `det_len`, loads `SIG_SEED` into the signature, and begins the run on the next cycle.
- R3: During the pseudo-random phase, which lasts exactly the latched `rand_len` cycles and always comes first, `mode_det` is 0 and `cut_in` equals `gen_word`.
- R4: During the deterministic phase, which lasts exactly the latched `det_len` cycles, `mode_det` is 1 and every `cut_in` bit whose `DIRECT_MASK` bit is 0 equals the same bit of `dec_word`.
- R5: Every `cut_in` bit whose `DIRECT_MASK` bit is 1 equals the same bit of `gen_word` in every cycle and phase.
- R6: A phase whose latched length is 0 is skipped. With both lengths 0, `done` rises in the cycle after the start pulse and the signature stays at `SIG_SEED`.
- R7: In each cycle of either phase, the signature S is updated to ((S shifted left by one, LSB 0) XOR (`SIG_POLY` if the MSB of S is 1, else 0)) XOR `cut_resp`. Outside the phases, the signature changes only on an accepted start.
- R8: `done` is 1 from the cycle after the last deterministic cycle (or the last random cycle if `det_len` is 0) until a start is accepted. While `done` is 1, `signature` holds its value.
- R9: A `start` pulse during either phase is ignored. Changes of `rand_len` and `det_len` after the start has been accepted do not affect the run in progress.
- R10: `gen_step` is 1 in exactly the cycles of the two phases, so it is 1 for `rand_len + det_len` cycles per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or finished) |
| rand_len | input | CNT_W | Length of the pseudo-random phase in cycles |
| det_len | input | CNT_W | Length of the deterministic phase in cycles |
| gen_word | input | WIDTH | Current pattern generator word |
| dec_word | input | WIDTH | Decoder transform of the current generator word |
| cut_resp | input | RESP_W | Response of the logic under test to `cut_in` |
| gen_step | output | 1 | Advance the pattern generator this cycle |
| cut_in | output | WIDTH | Pattern applied to the logic under test |
| mode_det | output | 1 | High during the deterministic phase |
| done | output | 1 | Run finished, signature final |
| signature | output | RESP_W | Compacted response signature |

## Verification
The bench builds the block with 8-bit patterns, responses and counters, `SIG_POLY` = 8'h1D, `SIG_SEED` = 8'hFF and `DIRECT_MASK` = 8'h81. Because the mask is non-zero, the straight-wired inputs on both edges of the word are checked against the raw generator bits while every other bit switches to the decoded word. The 8-bit counter makes short phases, zero-length phases and a mid-run restart attempt cheap to exercise. A reference signature is computed cycle by cycle from a modelled circuit under test.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAND = 2'd1,
        PH_DET  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // Phase entered when a run starts, skipping empty phases.
    function automatic phase_e first_phase(input logic rand_nz, input logic det_nz);
        if (rand_nz)
            return PH_RAND;
        else if (det_nz)
            return PH_DET;
        else
            return PH_DONE;
    endfunction

    // Phase entered when the pseudo-random phase ends.
    function automatic phase_e after_rand(input logic det_nz);
        return det_nz ? PH_DET : PH_DONE;
    endfunction

    function automatic logic is_active(input phase_e ph);
        return (ph == PH_RAND) || (ph == PH_DET);
    endfunction

    function automatic logic can_start(input phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_DONE);
    endfunction

endpackage

// File: rtl/bist_phase_ctrl.sv
module bist_phase_ctrl
    import bist_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] rand_len,
    input  logic [CNT_W-1:0] det_len,
    output phase_e           phase,
    output logic             active,
    output logic             load_seed
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rl_q, rl_d;
    logic [CNT_W-1:0] dl_q, dl_d;

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        rl_d  = rl_q;
        dl_d  = dl_q;
        unique case (ph_q)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    rl_d  = rand_len;
                    dl_d  = det_len;
                    cnt_d = '0;
                    ph_d  = first_phase(rand_len != '0, det_len != '0);
                end
            end
            PH_RAND: begin
                if (cnt_q == rl_q - ONE) begin
                    cnt_d = '0;
                    ph_d  = after_rand(dl_q != '0);
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            PH_DET: begin
                if (cnt_q == dl_q - ONE) begin
                    cnt_d = '0;
                    ph_d  = PH_DONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            rl_q  <= '0;
            dl_q  <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            rl_q  <= rl_d;
            dl_q  <= dl_d;
        end
    end

    assign phase     = ph_q;
    assign active    = is_active(ph_q);
    assign load_seed = start && can_start(ph_q);

endmodule

// File: rtl/bist_mux_switch.sv
module bist_mux_switch #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] MASK  = '0
) (
    input  logic             sel_dec,
    input  logic [WIDTH-1:0] raw,
    input  logic [WIDTH-1:0] dec,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (MASK[i]) begin : g_direct
            assign y[i] = raw[i];
        end else begin : g_mux
            assign y[i] = sel_dec ? dec[i] : raw[i];
        end
    end

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
    parameter int                W    = 8,
    parameter logic [W-1:0]      POLY = '1,
    parameter logic [W-1:0]      SEED = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         enable,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig
);
    logic [W-1:0] sig_q;
    logic [W-1:0] shifted;

    assign shifted = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0);

    always_ff @(posedge clk) begin
        if (rst || clear)
            sig_q <= SEED;
        else if (enable)
            sig_q <= shifted ^ resp;
    end

    assign sig = sig_q;

endmodule

// File: rtl/bist_phase_seq.sv
module bist_phase_seq
    import bist_seq_pkg::*;
#(
    parameter int                  WIDTH       = 8,
    parameter int                  RESP_W      = 8,
    parameter int                  CNT_W       = 16,
    parameter logic [WIDTH-1:0]    DIRECT_MASK = '0,
    parameter logic [RESP_W-1:0]   SIG_POLY    = RESP_W'(8'h1D),
    parameter logic [RESP_W-1:0]   SIG_SEED    = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  rand_len,
    input  logic [CNT_W-1:0]  det_len,
    input  logic [WIDTH-1:0]  gen_word,
    input  logic [WIDTH-1:0]  dec_word,
    input  logic [RESP_W-1:0] cut_resp,
    output logic              gen_step,
    output logic [WIDTH-1:0]  cut_in,
    output logic              mode_det,
    output logic              done,
    output logic [RESP_W-1:0] signature
);
    phase_e phase;
    logic   active;
    logic   load_seed;

    bist_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rand_len  (rand_len),
        .det_len   (det_len),
        .phase     (phase),
        .active    (active),
        .load_seed (load_seed)
    );

    bist_mux_switch #(.WIDTH(WIDTH), .MASK(DIRECT_MASK)) u_switch (
        .sel_dec (phase == PH_DET),
        .raw     (gen_word),
        .dec     (dec_word),
        .y       (cut_in)
    );

    bist_misr #(.W(RESP_W), .POLY(SIG_POLY), .SEED(SIG_SEED)) u_misr (
        .clk    (clk),
        .rst    (rst),
        .clear  (load_seed),
        .enable (active),
        .resp   (cut_resp),
        .sig    (signature)
    );

    assign gen_step = active;
    assign mode_det = (phase == PH_DET);
    assign done     = (phase == PH_DONE);

endmodule

// File: rtl/bist_phase_seq_chk.sv
module bist_phase_seq_chk #(
    parameter int               WIDTH  = 8,
    parameter int               RESP_W = 8,
    parameter logic [WIDTH-1:0] MASK   = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [WIDTH-1:0]  gen_word,
    input logic [WIDTH-1:0]  dec_word,
    input logic              gen_step,
    input logic [WIDTH-1:0]  cut_in,
    input logic              mode_det,
    input logic              done,
    input logic [RESP_W-1:0] signature
);
    // R5: straight-wired inputs always carry the raw bit
    a_r5_direct_raw: assert property (@(posedge clk) disable iff (rst)
        (cut_in & MASK) == (gen_word & MASK));

    // R3: outside the deterministic phase the raw word reaches the logic
    a_r3_raw_path: assert property (@(posedge clk) disable iff (rst)
        !mode_det |-> cut_in == gen_word);

    // R4: in the deterministic phase multiplexed bits carry the decoded word
    a_r4_dec_path: assert property (@(posedge clk) disable iff (rst)
        mode_det |-> (cut_in & ~MASK) == (dec_word & ~MASK));

    // R8: finished run holds its signature and its done flag
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(signature)));

    // R10: generator never steps in a finished run; R4 mode implies stepping
    a_r10_step_phase: assert property (@(posedge clk) disable iff (rst)
        (!(gen_step && done)) && (!mode_det || gen_step));

    // R7: no compaction when the generator is idle and no start arrives
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!gen_step && !start) |=> $stable(signature));

endmodule

bind bist_phase_seq bist_phase_seq_chk #(
    .WIDTH (WIDTH),
    .RESP_W(RESP_W),
    .MASK  (DIRECT_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .gen_word  (gen_word),
    .dec_word  (dec_word),
    .gen_step  (gen_step),
    .cut_in    (cut_in),
    .mode_det  (mode_det),
    .done      (done),
    .signature (signature)
);

// File: tb/sim_bist_phase_seq.sv
module sim_bist_phase_seq;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 8;
    localparam logic [7:0]  MASK       = 8'h81;
    localparam logic [7:0]  POLY       = 8'h1D;
    localparam logic [7:0]  SEED       = 8'hFF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] rand_len = '0, det_len = '0;
    logic [7:0] gen_word = 8'h01, dec_word = '0;
    logic [7:0] cut_resp;
    logic       gen_step, mode_det, done;
    logic [7:0] cut_in, signature;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] g_state = 8'h5B;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Modelled logic under test
    function automatic logic [7:0] cut_model(input logic [7:0] x);
        return (x ^ {x[4:0], x[7:5]}) ^ 8'h3C;
    endfunction
    assign cut_resp = cut_model(cut_in);

    bist_phase_seq #(
        .WIDTH(W), .RESP_W(8), .CNT_W(8),
        .DIRECT_MASK(MASK), .SIG_POLY(POLY), .SIG_SEED(SEED)
    ) u0 (
        .clk(clk), .rst(rst), .start(start),
        .rand_len(rand_len), .det_len(det_len),
        .gen_word(gen_word), .dec_word(dec_word), .cut_resp(cut_resp),
        .gen_step(gen_step), .cut_in(cut_in), .mode_det(mode_det),
        .done(done), .signature(signature)
    );

    function automatic logic [7:0] sig_next(input logic [7:0] s, input logic [7:0] r);
        return ({s[6:0], 1'b0} ^ (s[7] ? POLY : 8'h00)) ^ r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic new_words();
        g_state  = {g_state[6:0], g_state[7] ^ g_state[5] ^ g_state[4] ^ g_state[3]};
        gen_word = g_state;
        dec_word = ~g_state ^ 8'h5A;
    endtask

    // One full run; inputs change at falling edges, checks 1 time unit later.
    task automatic do_run(input int rl, input int dl, input bit poke_start, input string tag);
        logic [7:0] exp_sig;
        logic [7:0] exp_in;
        @(negedge clk);
        start = 1'b1; rand_len = 8'(rl); det_len = 8'(dl);
        @(negedge clk);
        start = 1'b0;
        rand_len = 8'hFF; det_len = 8'hFF;      // R9: post-start changes ignored
        exp_sig = SEED;
        for (int i = 0; i < rl; i++) begin
            new_words();
            start = (poke_start && i == 1);      // R9: mid-run start ignored
            #1;
            check({tag, " R3 mode"}, mode_det, 0);
            check({tag, " R10 step"}, gen_step, 1);
            check({tag, " R3 cut_in"}, cut_in, gen_word);
            check({tag, " R8 not done"}, done, 0);
            exp_sig = sig_next(exp_sig, cut_model(gen_word));
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < dl; i++) begin
            new_words();
            start = (poke_start && rl == 0 && i == 1);
            #1;
            exp_in = (gen_word & MASK) | (dec_word & ~MASK);
            check({tag, " R4 mode"}, mode_det, 1);
            check({tag, " R10 step"}, gen_step, 1);
            check({tag, " R4/R5 cut_in"}, cut_in, exp_in);
            exp_sig = sig_next(exp_sig, cut_model(exp_in));
            @(negedge clk);
            start = 1'b0;
        end
        #1;
        check({tag, " R8 done"}, done, 1);
        check({tag, " R10 idle step"}, gen_step, 0);
        check({tag, " R7 signature"}, signature, exp_sig);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            new_words();
            #1;
            check({tag, " R8 hold done"}, done, 1);
            check({tag, " R8 hold sig"}, signature, exp_sig);
            check({tag, " R3 idle raw"}, cut_in, gen_word);
        end
    endtask

    task automatic t_reset();
        #1;
        check("R1 done", done, 0);
        check("R1 mode", mode_det, 0);
        check("R1 step", gen_step, 0);
        check("R1 signature", signature, SEED);
    endtask

    task automatic t_empty();
        // R6: both phases empty
        @(negedge clk);
        start = 1'b1; rand_len = 0; det_len = 0;
        @(negedge clk);
        start = 1'b0;
        #1;
        check("R6 done next cycle", done, 1);
        check("R6 seed kept", signature, SEED);
        check("R6 no step", gen_step, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        do_run(5, 3, 0, "R2 basic");
        do_run(0, 4, 0, "R6 no-rand");
        do_run(4, 0, 0, "R6 no-det");
        do_run(6, 5, 1, "R9 restart-ignored");
        do_run(1, 1, 0, "R2 minimal");
        t_empty();
        do_run(20, 12, 0, "R7 long");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule